// File: doc/BRIEF.md
# Cache Lock Stack Controller

This block keeps the pointer that decides which slots of an instruction cache are pinned. Locked slots form a stack that grows downward from the top slot index. Each time software reads a constant out of code memory while pushing is enabled, the slot under the pointer is reserved for that 4-byte segment and the pointer steps down one. A pop strobe steps the pointer back up, and that slot becomes free again. A pointer value of zero releases every slot at once.

The controller does not move any data. It issues a one-cycle lock request that names the target slot, so that the cache fill logic can load the segment there. It also gives the replacement logic a full per-slot locked mask, and a single locked flag for a queried slot index. Software sees an 8-bit control word. Only the push-enable bit and the pop strobe in that word can be written.

Top module: `cache_lock_stack`

## Requirements
- R1: After reset the pointer is 62, push-enable is 0, the read value is 0x3E and no lock request is raised.
- R2: While push-enable is 1 and the pointer is nonzero, a code-table read in a cycle with no pop request does two things one cycle later. It raises lock_req for one cycle with lock_slot equal to the old pointer, and it leaves the pointer one lower.
- R3: A register write with bit 6 set, while the pointer is below 62, raises the pointer by one in the next cycle, and the slot at the new pointer reads as unlocked.
- R4: The read value is {push-enable at bit 7, 0 at bit 6, pointer at bits 5:0}, so the pop bit always reads 0.
- R5: Bit i of the locked mask (slots 0 to 62) is 1 exactly when the pointer is nonzero and i is greater than the pointer.
- R6: With the pointer at 0 no slot is locked, and a code-table read is ignored: no request is raised and the pointer stays 0.
- R7: A pop request while the pointer is 62 is ignored, so the pointer never goes above 62.
- R8: When a pop request and a code-table read arrive in the same cycle, the pop is carried out and no lock request is raised.
- R9: query_locked equals the locked-mask bit at query_idx, and it is 0 for an index above 62.
- R10: Bits 5:0 of a register write never change the pointer. Bit 7 of every write sets push-enable, and the new value takes effect from the next cycle.
- R11: A code-table read while push-enable is 0 raises no request and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control-word write strobe |
| reg_wdata | input | 8 | Write data: bit 7 push-enable, bit 6 pop |
| table_rd | input | 1 | Code-memory constant read event |
| query_idx | input | 6 | Slot index to test |
| reg_rdata | output | 8 | Control-word read value |
| slot_ptr | output | 6 | Current stack pointer |
| lock_req | output | 1 | One-cycle request to lock a segment |
| lock_slot | output | 6 | Slot targeted by lock_req |
| locked_mask | output | 63 | Per-slot locked flags |
| query_locked | output | 1 | Locked flag of query_idx |

## Verification
The assertions assume that reg_wr and table_rd are sampled only on rising edges, and that query_idx carries a defined value whenever the mask is checked. They make no assumption about balanced push and pop counts, because the block itself clamps the pointer at 0 and 62. The stimulus therefore drives the clamped boundaries on purpose: it pushes all the way down to 0 and pops at 62. Every input changes on the falling edge, so no edge ever sees an input in the middle of a change.

// File: rtl/cls_pkg.sv
package cls_pkg;
    localparam int PTR_W    = 6;
    localparam int PUSH_BIT = 7;
    localparam int POP_BIT  = 6;
    localparam int REG_W    = PTR_W + 2;

    typedef logic [PTR_W-1:0] slot_t;

    typedef struct packed {
        logic  push_en;
        slot_t ptr;
        logic  lock_req;
        slot_t lock_slot;
    } ctl_state_t;
endpackage

// File: rtl/cls_ptr_ctrl.sv
module cls_ptr_ctrl
    import cls_pkg::*;
#(
    parameter int PTR_TOP = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             table_rd,
    output logic             push_en,
    output slot_t            ptr,
    output logic             lock_req,
    output slot_t            lock_slot
);
    localparam slot_t TOP = slot_t'(PTR_TOP);

    ctl_state_t st_d, st_q;
    logic pop_req, pop_ok, push_ok;

    always_comb begin
        pop_req = reg_wr && reg_wdata[POP_BIT];
        pop_ok  = pop_req && (st_q.ptr != TOP);
        push_ok = table_rd && st_q.push_en && (st_q.ptr != '0) && !pop_req;

        st_d          = st_q;
        st_d.lock_req = push_ok;
        if (reg_wr) begin
            st_d.push_en = reg_wdata[PUSH_BIT];
        end
        if (pop_ok) begin
            st_d.ptr = st_q.ptr + slot_t'(1);
        end else if (push_ok) begin
            st_d.ptr       = st_q.ptr - slot_t'(1);
            st_d.lock_slot = st_q.ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.push_en   <= 1'b0;
            st_q.ptr       <= TOP;
            st_q.lock_req  <= 1'b0;
            st_q.lock_slot <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_en   = st_q.push_en;
    assign ptr       = st_q.ptr;
    assign lock_req  = st_q.lock_req;
    assign lock_slot = st_q.lock_slot;

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (table_rd && push_en && ptr != '0 && !(reg_wr && reg_wdata[POP_BIT]))
        |=> (lock_req && lock_slot == $past(ptr) && ptr == $past(ptr) - slot_t'(1))); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[POP_BIT] && ptr != TOP)
        |=> (ptr == $past(ptr) + slot_t'(1) && !lock_req)); // R3
    AST_PTR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= TOP); // R7
    AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0 && !(reg_wr && reg_wdata[POP_BIT])) |=> (ptr == '0 && !lock_req)); // R6
    AST_NO_PUSH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_en && !(reg_wr && reg_wdata[POP_BIT])) |=> ($stable(ptr) && !lock_req)); // R11
endmodule

// File: rtl/cls_lock_map.sv
module cls_lock_map
    import cls_pkg::*;
#(
    parameter int PTR_TOP = 62,
    localparam int NSLOTS = PTR_TOP + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_t             ptr,
    input  slot_t             query_idx,
    output logic [NSLOTS-1:0] mask,
    output logic              query_locked
);
    logic [NSLOTS-1:0] sel;

    for (genvar i = 0; i < NSLOTS; i++) begin : g_slot
        assign mask[i] = (ptr != '0) && (slot_t'(i) > ptr);
        assign sel[i]  = (query_idx == slot_t'(i));
    end

    assign query_locked = |(mask & sel);

    AST_MASK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != '0) |-> ($countones(mask) == PTR_TOP - int'(ptr))); // R5
    AST_ZERO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0) |-> (mask == '0)); // R6
    AST_QUERY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (query_idx > slot_t'(PTR_TOP)) |-> !query_locked); // R9
endmodule

// File: rtl/cache_lock_stack.sv
module cache_lock_stack
    import cls_pkg::*;
#(
    parameter int PTR_TOP = 62,
    localparam int NSLOTS = PTR_TOP + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              table_rd,
    input  logic [PTR_W-1:0]  query_idx,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [PTR_W-1:0]  slot_ptr,
    output logic              lock_req,
    output logic [PTR_W-1:0]  lock_slot,
    output logic [NSLOTS-1:0] locked_mask,
    output logic              query_locked
);
    logic  push_en;
    slot_t ptr;

    cls_ptr_ctrl #(.PTR_TOP(PTR_TOP)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .table_rd  (table_rd),
        .push_en   (push_en),
        .ptr       (ptr),
        .lock_req  (lock_req),
        .lock_slot (lock_slot)
    );

    cls_lock_map #(.PTR_TOP(PTR_TOP)) map_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ptr          (ptr),
        .query_idx    (query_idx),
        .mask         (locked_mask),
        .query_locked (query_locked)
    );

    assign slot_ptr  = ptr;
    assign reg_rdata = {push_en, 1'b0, ptr};

    AST_POP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[POP_BIT]); // R4
endmodule

// File: tb/cache_lock_stack_tb_top.sv
module cache_lock_stack_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TOP = 62;
    localparam int NV  = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       table_rd = 1'b0;
    logic [5:0] query_idx = '0;
    logic [7:0] reg_rdata;
    logic [5:0] slot_ptr;
    logic       lock_req;
    logic [5:0] lock_slot;
    logic [TOP:0] locked_mask;
    logic       query_locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_lock_stack dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .table_rd(table_rd), .query_idx(query_idx), .reg_rdata(reg_rdata),
        .slot_ptr(slot_ptr), .lock_req(lock_req), .lock_slot(lock_slot),
        .locked_mask(locked_mask), .query_locked(query_locked)
    );

    // {wr, wdata[8], rd, exp_pe, exp_ptr[6], exp_lr, exp_slot[6]}
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 8'h80, 1'b0, 1'b1, 6'd62, 1'b0, 6'd0},   // R10 enable push
        {1'b0, 8'h00, 1'b1, 1'b1, 6'd61, 1'b1, 6'd62},  // R2
        {1'b0, 8'h00, 1'b1, 1'b1, 6'd60, 1'b1, 6'd61},  // R2
        {1'b0, 8'h00, 1'b0, 1'b1, 6'd60, 1'b0, 6'd0},   // idle
        {1'b1, 8'hC0, 1'b0, 1'b1, 6'd61, 1'b0, 6'd0},   // R3
        {1'b1, 8'hC0, 1'b1, 1'b1, 6'd62, 1'b0, 6'd0},   // R8
        {1'b1, 8'hC0, 1'b0, 1'b1, 6'd62, 1'b0, 6'd0},   // R7
        {1'b1, 8'h3F, 1'b0, 1'b0, 6'd62, 1'b0, 6'd0},   // R10 ptr bits ignored
        {1'b0, 8'h00, 1'b1, 1'b0, 6'd62, 1'b0, 6'd0},   // R11
        {1'b1, 8'h80, 1'b0, 1'b1, 6'd62, 1'b0, 6'd0},   // R10
        {1'b0, 8'h00, 1'b1, 1'b1, 6'd61, 1'b1, 6'd62}   // R2
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cnt(input int p);
        return (p == 0) ? 0 : TOP - p;
    endfunction

    task automatic step(input logic wr, input logic [7:0] wd, input logic rd);
        reg_wr = wr; reg_wdata = wd; table_rd = rd;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; table_rd = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ptr", slot_ptr, 62);
        check("R1 rdata", reg_rdata, 8'h3E);
        check("R1 lock_req", lock_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            int p;
            e = VEC[v];
            step(e[23], e[22:15], e[14]);
            p = int'(e[12:7]);
            check("R2/R3 ptr", slot_ptr, p);
            check("R2/R8 lock_req", lock_req, int'(e[6]));
            if (e[6]) check("R2 lock_slot", lock_slot, int'(e[5:0]));
            check("R4 rdata", reg_rdata, int'({e[13], 1'b0, e[12:7]}));
            check("R5 mask count", $countones(locked_mask), exp_cnt(p));
        end

        // R9 query at ptr 61
        query_idx = 6'd62; #1;
        check("R9 query above ptr", query_locked, 1);
        query_idx = 6'd61; #1;
        check("R9 query at ptr", query_locked, 0);
        query_idx = 6'd63; #1;
        check("R9 query out of range", query_locked, 0);

        // R2 drain to zero
        for (int k = 0; k < 61; k++) step(1'b0, 8'h00, 1'b1);
        check("R6 ptr at zero", slot_ptr, 0);
        check("R6 mask empty", $countones(locked_mask), 0);
        query_idx = 6'd62; #1;
        check("R6 query at zero", query_locked, 0);
        step(1'b0, 8'h00, 1'b1);
        check("R6 push ignored ptr", slot_ptr, 0);
        check("R6 push ignored req", lock_req, 0);

        // R3 pop from zero
        step(1'b1, 8'hC0, 1'b0);
        check("R3 pop ptr", slot_ptr, 1);
        check("R5 mask count after pop", $countones(locked_mask), 61);
        check("R3 new ptr slot free", locked_mask[1], 0);
        check("R5 slot 2 locked", locked_mask[2], 1);

        // R1 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset ptr", slot_ptr, 62);
        check("R1 reset rdata", reg_rdata, 8'h3E);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule